// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a free-running 63-bit cycle count and a 63-bit compare value. Software-style writes load either register from a shared 64-bit write bus. The top bit of each is a control flag, not a data bit. In the count register it is a stored trap-on-user-read flag. In the compare register it is an interrupt-disable flag. The count advances on every clock cycle in which the prescale enable input is high. The nominal step rate is 100 MHz for every instance.

A compare write arms a one-shot match. The match is armed only when the compare value is non-zero and the disable flag is clear. While armed, the first count step whose new value is at or above the compare value drives a one-cycle set pulse toward a soft-interrupt register. The match then disarms until the next compare write. A compare value that is already behind the count fires on the very next step, so the event is never lost.

One parameter picks the flavour: plain tick, system tick or hypervisor system tick. The flavour sets which bit of the 17-bit set vector is pulsed. The soft-interrupt register and the priority logic that consumes it sit outside this block.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the count is zero, the trap flag is 1 (count read = 0x8000_0000_0000_0000), the disable flag is 1 with compare value zero (compare read = 0x8000_0000_0000_0000), and no set pulse is driven.
- R2: A count write loads bits 62:0 into the count and stores bit 63 as the trap flag. A count read returns the count in bits 62:0 and the trap flag in bit 63.
- R3: The count increases by one on each cycle with the enable high. It holds when the enable is low. A count write in the same cycle takes priority over the increment.
- R4: A compare write stores bit 63 as the disable flag and bits 62:0 as the compare value. A compare read returns them in the same positions.
- R5: With the match armed, the step whose new count equals the compare value raises the set pulse for exactly one cycle. The pulse appears in the cycle after that clock edge, together with the new count.
- R6: A compare value written at or below the current count fires on the next count step.
- R7: A compare value of zero, or a compare write with bit 63 set, cancels any armed match. No pulse follows, however far the count advances.
- R8: A match fires once per compare write. Later steps past the compare value raise no pulse until the compare register is written again, which re-arms the match.
- R9: The set pulse drives only the target bit of the 17-bit set vector. The target is bit 0 for the tick flavour and bit 16 for both the system and hypervisor flavours.
- R10: A compare write in the same cycle as a step that would have matched suppresses that match. The newly written compare value governs from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Prescaled count enable; one step per high cycle |
| cnt_wr | input | 1 | Write strobe for the count register |
| lim_wr | input | 1 | Write strobe for the compare register |
| wr_data | input | 64 | Write data shared by both registers |
| cnt_rd_data | output | 64 | Count read: trap flag in bit 63, count in 62:0 |
| lim_rd_data | output | 64 | Compare read: disable flag in bit 63, value in 62:0 |
| softint_set | output | 17 | One-cycle pulse on the flavour's soft-interrupt bit |

## Verification
Both read ports come straight from registers. A write or count step sampled at one rising edge is therefore visible in the cycle that follows that edge, with no further delay. The set pulse is registered in step with the count, so it appears in the same cycle as the count value that matched and is gone one cycle later. The bench changes inputs on the falling edge and samples on the next falling edge, so each check sees exactly one rising edge's worth of change. Pulse checks are made on every cycle of a stepping run, not only on the expected cycle.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;

    typedef enum logic [1:0] {
        TMR_TICK = 2'd0,
        TMR_SYS  = 2'd1,
        TMR_HYP  = 2'd2
    } tmr_kind_e;

    localparam int SOFTINT_W  = 17;
    localparam int TICK_BIT   = 0;
    localparam int SYSTIM_BIT = 16;

    function automatic int target_bit(tmr_kind_e kind);
        return (kind == TMR_TICK) ? TICK_BIT : SYSTIM_BIT;
    endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_en,
    input  logic                cnt_wr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-2:0]   cnt_o,
    output logic                flag_o,
    output logic                step_o,
    output logic [DATA_W-2:0]   next_o
);
    localparam int CNT_W = DATA_W - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] inc_d;
    logic             step_d;

    always_comb begin
        st_d   = st_q;
        inc_d  = st_q.cnt + CNT_W'(1);
        step_d = cnt_en & ~cnt_wr;
        if (cnt_wr) begin
            st_d.cnt  = wr_data[CNT_W-1:0];
            st_d.flag = wr_data[DATA_W-1];
        end else if (cnt_en) begin
            st_d.cnt = inc_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign flag_o = st_q.flag;
    assign step_o = step_d;
    assign next_o = inc_d;

    // R3: a step advances the count by one
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_wr) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    // R3: no enable, no write -> count holds
    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_wr) |=> $stable(st_q.cnt));

    // R2: count write loads value and flag
    assert_count_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (st_q.cnt == $past(wr_data[CNT_W-1:0]))
                   && (st_q.flag == $past(wr_data[DATA_W-1])));

endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lim_wr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                step_i,
    input  logic [DATA_W-2:0]   next_i,
    output logic [DATA_W-2:0]   lim_o,
    output logic                dis_o,
    output logic                fire_o
);
    localparam int CNT_W = DATA_W - 1;

    typedef struct packed {
        logic [CNT_W-1:0] lim;
        logic             dis;
        logic             armed;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       fire_d;

    always_comb begin
        st_d   = st_q;
        fire_d = st_q.armed & step_i & ~lim_wr & (next_i >= st_q.lim);
        if (lim_wr) begin
            st_d.lim   = wr_data[CNT_W-1:0];
            st_d.dis   = wr_data[DATA_W-1];
            st_d.armed = ~wr_data[DATA_W-1] & (|wr_data[CNT_W-1:0]);
        end else if (fire_d) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lim   <= '0;
            st_q.dis   <= 1'b1;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lim_o  = st_q.lim;
    assign dis_o  = st_q.dis;
    assign fire_o = fire_d;

    // R7: disable flag on write leaves nothing armed
    assert_disable_cancels_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_wr && wr_data[DATA_W-1]) |=> !st_q.armed);

    // R7: zero compare value leaves nothing armed
    assert_zero_cancels_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_wr && wr_data[CNT_W-1:0] == '0) |=> !st_q.armed);

    // R8: a match disarms until the next write
    assert_one_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_d |=> !st_q.armed);

    // R4: compare register loads both fields
    assert_limit_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lim_wr |=> (st_q.lim == $past(wr_data[CNT_W-1:0]))
                   && (st_q.dis == $past(wr_data[DATA_W-1])));

endmodule

// File: rtl/tick_irq_route.sv
module tick_irq_route #(
    parameter int SET_W = 17,
    parameter int TGT   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    output logic [SET_W-1:0] set_o
);
    localparam logic [SET_W-1:0] TGT_MASK = SET_W'(1) << TGT;

    typedef struct packed {
        logic [SET_W-1:0] set;
    } route_state_t;

    route_state_t st_d, st_q;

    always_comb begin
        st_d.set = fire_i ? TGT_MASK : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.set <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign set_o = st_q.set;

    // R9: pulse touches only the target bit
    assert_target_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_o) && ((set_o & ~TGT_MASK) == '0));

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tick_cmp_pkg::*;
#(
    parameter int        DATA_W = 64,
    parameter tmr_kind_e KIND   = TMR_TICK
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cnt_en,
    input  logic                 cnt_wr,
    input  logic                 lim_wr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    cnt_rd_data,
    output logic [DATA_W-1:0]    lim_rd_data,
    output logic [SOFTINT_W-1:0] softint_set
);
    localparam int CNT_W = DATA_W - 1;
    localparam int TGT   = target_bit(KIND);

    logic [CNT_W-1:0] cnt_w, next_w, lim_w;
    logic             flag_w, step_w, dis_w, fire_w;

    tick_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .cnt_wr  (cnt_wr),
        .wr_data (wr_data),
        .cnt_o   (cnt_w),
        .flag_o  (flag_w),
        .step_o  (step_w),
        .next_o  (next_w)
    );

    tick_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .lim_wr  (lim_wr),
        .wr_data (wr_data),
        .step_i  (step_w),
        .next_i  (next_w),
        .lim_o   (lim_w),
        .dis_o   (dis_w),
        .fire_o  (fire_w)
    );

    tick_irq_route #(.SET_W(SOFTINT_W), .TGT(TGT)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire_w),
        .set_o  (softint_set)
    );

    assign cnt_rd_data = {flag_w, cnt_w};
    assign lim_rd_data = {dis_w, lim_w};

    // R8: a pulse never lasts two cycles
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (softint_set != '0) |=> (softint_set == '0));

    // R10: a compare write cycle produces no pulse next cycle
    assert_write_suppress_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lim_wr |=> (softint_set == '0));

    // R5: a pulse only follows a counting cycle
    assert_pulse_on_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (softint_set != '0) |-> $past(cnt_en && !cnt_wr));

endmodule

// File: tb/tick_cmp_timer_tb_top.sv
module tick_cmp_timer_tb_top;
    import tick_cmp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, cnt_wr = 1'b0, lim_wr = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] cnt_rd_data, lim_rd_data, cnt_rd_h, lim_rd_h;
    logic [16:0] softint_set, softint_h;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [16:0] TICK_M = 17'h00001;
    localparam logic [16:0] SYS_M  = 17'h10000;

    always #2 clk = ~clk;

    tick_cmp_timer #(.DATA_W(64), .KIND(TMR_TICK)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_wr(cnt_wr),
        .lim_wr(lim_wr), .wr_data(wr_data), .cnt_rd_data(cnt_rd_data),
        .lim_rd_data(lim_rd_data), .softint_set(softint_set));

    tick_cmp_timer #(.DATA_W(64), .KIND(TMR_HYP)) dut_h (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_wr(cnt_wr),
        .lim_wr(lim_wr), .wr_data(wr_data), .cnt_rd_data(cnt_rd_h),
        .lim_rd_data(lim_rd_h), .softint_set(softint_h));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle from a falling edge, return at the next falling edge
    task automatic cyc(input logic en, input logic cw, input logic lw, input logic [63:0] d);
        cnt_en = en; cnt_wr = cw; lim_wr = lw; wr_data = d;
        @(negedge clk);
        cnt_en = 1'b0; cnt_wr = 1'b0; lim_wr = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset;
        chk("R1 count", cnt_rd_data, 64'h8000_0000_0000_0000);
        chk("R1 limit", lim_rd_data, 64'h8000_0000_0000_0000);
        chk("R1 set", {47'd0, softint_set}, 64'd0);
    endtask

    task automatic t_count;
        cyc(0, 1, 0, 64'h0000_0000_0000_1234);
        chk("R2 plain load", cnt_rd_data, 64'h0000_0000_0000_1234);
        cyc(0, 1, 0, 64'h8000_0000_0000_0055);
        chk("R2 flag load", cnt_rd_data, 64'h8000_0000_0000_0055);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, '0);
        chk("R3 hold", cnt_rd_data, 64'h8000_0000_0000_0055);
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, '0);
        chk("R3 five steps", cnt_rd_data, 64'h8000_0000_0000_005A);
        cyc(1, 1, 0, 64'h0000_0000_0000_0010);
        chk("R3 write beats step", cnt_rd_data, 64'h0000_0000_0000_0010);
    endtask

    task automatic t_limit;
        cyc(0, 0, 1, 64'h0123_4567_89AB_CDEF);
        chk("R4 value", lim_rd_data, 64'h0123_4567_89AB_CDEF);
        cyc(0, 0, 1, 64'hFFFF_0000_0000_0001);
        chk("R4 disable", lim_rd_data, 64'hFFFF_0000_0000_0001);
    endtask

    task automatic t_match;
        cyc(0, 1, 0, 64'h100);
        cyc(0, 0, 1, 64'h104);
        for (int i = 1; i <= 4; i++) begin
            cyc(1, 0, 0, '0);
            chk("R5 count", cnt_rd_data, 64'h100 + 64'(i));
            chk("R5 pulse", {47'd0, softint_set}, (i == 4) ? 64'(TICK_M) : 64'd0);
            chk("R9 hyp bit", {47'd0, softint_h}, (i == 4) ? 64'(SYS_M) : 64'd0);
        end
        for (int i = 0; i < 4; i++) begin
            cyc(1, 0, 0, '0);
            chk("R8 no repeat", {47'd0, softint_set}, 64'd0);
        end
        cyc(0, 0, 1, 64'h10A);
        cyc(1, 0, 0, '0);
        chk("R8 rearm wait", {47'd0, softint_set}, 64'd0);
        cyc(1, 0, 0, '0);
        chk("R8 rearm fire", {47'd0, softint_set}, 64'(TICK_M));
    endtask

    task automatic t_past;
        cyc(0, 1, 0, 64'h500);
        cyc(0, 0, 1, 64'h200);
        chk("R6 no pulse on write", {47'd0, softint_set}, 64'd0);
        cyc(0, 0, 0, '0);
        chk("R6 no pulse idle", {47'd0, softint_set}, 64'd0);
        cyc(1, 0, 0, '0);
        chk("R6 late fire", {47'd0, softint_set}, 64'(TICK_M));
    endtask

    task automatic t_cancel;
        int seen;
        cyc(0, 1, 0, 64'h600);
        cyc(0, 0, 1, 64'h602);
        cyc(0, 0, 1, 64'h0);
        chk("R7 zero read", lim_rd_data, 64'h0);
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            cyc(1, 0, 0, '0);
            if (softint_set != '0) seen++;
        end
        chk("R7 zero cancels", 64'(seen), 64'd0);
        cyc(0, 0, 1, 64'h610);
        cyc(0, 0, 1, 64'h8000_0000_0000_0610);
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            cyc(1, 0, 0, '0);
            if (softint_set != '0) seen++;
        end
        chk("R7 disable cancels", 64'(seen), 64'd0);
    endtask

    task automatic t_suppress;
        cyc(0, 1, 0, 64'h700);
        cyc(0, 0, 1, 64'h701);
        cyc(1, 0, 1, 64'h705);
        chk("R10 suppressed", {47'd0, softint_set}, 64'd0);
        chk("R10 count moved", cnt_rd_data, 64'h701);
        for (int i = 2; i <= 4; i++) begin
            cyc(1, 0, 0, '0);
            chk("R10 wait", {47'd0, softint_set}, 64'd0);
        end
        cyc(1, 0, 0, '0);
        chk("R10 new value fires", {47'd0, softint_set}, 64'(TICK_M));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_limit();
        t_match();
        t_past();
        t_cancel();
        t_suppress();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule